// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between the register side of an SPI controller and its serial shift engine. It holds a transmit FIFO that software fills and the engine drains, and a receive FIFO that the engine fills and software drains. From the two fill levels, a small set of programmable thresholds and a few sticky error events, it derives a status word, raw and masked interrupt vectors, a single interrupt line, and one request line per direction for a DMA controller.

Register accesses appear as one-cycle write strobes that share a single data bus. Data-port accesses appear as push and read strobes. The serial engine is represented by pop and push ports plus two busy inputs. A block enable acts as the run control. While the enable is low, both FIFOs are held empty and the threshold registers can be written. While it is high, the threshold registers are locked.

All flags are decoded from registered state, so they change in the cycle after the strobe that caused the change. FIFO read data is registered: a pop or read strobe updates the data output at the same clock edge that updates the level.

Top module: `spi_fifo_stat_irq`

## Requirements
- R1: After reset, both levels are 0. The status word is 0x0C while both busy inputs are low. The raw interrupt vector is 0x01. The masked vector, the interrupt line, both DMA requests and both data outputs are 0.
- R2: Each FIFO returns words in the order they were written. The level rises by one for each accepted write and falls by one for each accepted read. Read data appears on the data output right after the read strobe. A pop from an empty transmit FIFO leaves the level at 0 and drives zero data.
- R3: A transmit write while the level equals DEPTH is dropped: the level stays at DEPTH, the stored words are unchanged, and raw bit 1 (transmit overflow) is set.
- R4: A bus read of an empty receive FIFO returns zero and sets raw bit 2 (receive underflow). An engine push into a full receive FIFO is dropped and sets raw bit 3 (receive overflow).
- R5: The status bits are: bit 0 engine busy, bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full, bit 5 slave-transmit busy.
- R6: Raw bit 4 is 1 exactly when the receive level is greater than the receive threshold, which means at least the threshold plus one. Raw bit 0 is 1 exactly when the transmit level is at or below the transmit threshold.
- R7: A write to any of the four threshold registers (transmit, receive, transmit DMA, receive DMA) takes effect only while the enable is low. A write made while the enable is high is ignored.
- R8: Raw bits 1, 2 and 3 are sticky. A clear write with data bit 0 set clears all three. Data bit 1 clears receive underflow (raw bit 2), data bit 2 clears receive overflow (raw bit 3), and data bit 3 clears transmit overflow (raw bit 1). If a new event and its clear fall in the same cycle, the event wins.
- R9: The masked vector equals the raw vector ANDed with the 5-bit mask register. The interrupt line is the OR of the masked bits.
- R10: In the DMA enable register, data bit 0 enables receive requests and data bit 1 enables transmit requests. The receive request is high when the receive level exceeds the receive DMA level. The transmit request is high when the transmit level is at or below the transmit DMA level. Both requests are low while the enable is low.
- R11: While the enable is low, both FIFOs are emptied, both levels read 0, and writes, pushes, pops and reads neither store data nor raise any error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low flushes the FIFOs and unlocks the thresholds |
| tx_wr | input | 1 | Bus write strobe to the transmit data port |
| tx_wdata | input | DW | Transmit write data |
| rx_rd | input | 1 | Bus read strobe from the receive data port |
| rx_rdata | output | DW | Registered receive read data |
| eng_pop | input | 1 | Engine pop from the transmit FIFO |
| eng_txdata | output | DW | Registered transmit word for the engine |
| eng_push | input | 1 | Engine push into the receive FIFO |
| eng_rxdata | input | DW | Received word from the engine |
| eng_busy | input | 1 | Engine busy indication |
| eng_slv_busy | input | 1 | Engine slave-transmit busy indication |
| reg_wdata | input | REGW | Shared register write data |
| txthr_wr | input | 1 | Transmit threshold write strobe |
| rxthr_wr | input | 1 | Receive threshold write strobe |
| txdlvl_wr | input | 1 | Transmit DMA level write strobe |
| rxdlvl_wr | input | 1 | Receive DMA level write strobe |
| mask_wr | input | 1 | Interrupt mask write strobe |
| clr_wr | input | 1 | Interrupt clear write strobe |
| dmaen_wr | input | 1 | DMA enable write strobe |
| tx_level | output | clog2(DEPTH+1) | Transmit fill level |
| rx_level | output | clog2(DEPTH+1) | Receive fill level |
| status | output | 6 | Status word |
| irq_raw | output | 5 | Raw interrupt vector |
| irq_masked | output | 5 | Masked interrupt vector |
| irq | output | 1 | Interrupt line |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The assertions check the following on every cycle: that the levels stay within DEPTH and move by at most one per cycle, that a disable empties both FIFOs on the next cycle, that overflow and underflow set their sticky bits, that the sticky receive overflow bit survives until a clear, that the masked vector and the interrupt line are consistent with the raw vector, and that DMA requests stay low while the block is disabled. Other behaviours need programmed sequences that only the bench's scenarios provide. These are: word ordering through each FIFO; dropped words staying out of a full FIFO; the crossed bit order of the clear register; locking of the threshold registers while enabled; and the exact threshold boundaries for the interrupts and DMA requests.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  // status word bit positions
  localparam int ST_BUSY    = 0;
  localparam int ST_TXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_RXEMPTY = 3;
  localparam int ST_RXFULL  = 4;
  localparam int ST_SLVBUSY = 5;
  localparam int NST        = 6;

  // interrupt vector bit positions (mask, raw and masked share them)
  localparam int IR_TXEMPTY = 0;
  localparam int IR_TXOVF   = 1;
  localparam int IR_RXUND   = 2;
  localparam int IR_RXOVF   = 3;
  localparam int IR_RXTHR   = 4;
  localparam int NIRQ       = 5;

  // clear register bit positions (different order from the vector)
  localparam int CL_ALL   = 0;
  localparam int CL_RXUND = 1;
  localparam int CL_RXOVF = 2;
  localparam int CL_TXOVF = 3;
  localparam int NCLR     = 4;

  // DMA enable bits
  localparam int DE_RX = 0;
  localparam int DE_TX = 1;
  localparam int NDE   = 2;

  // threshold register slots
  localparam int TH_TX  = 0;
  localparam int TH_RX  = 1;
  localparam int TH_TXD = 2;
  localparam int TH_RXD = 3;
  localparam int NTH    = 4;

  typedef struct packed {
    logic tx_ovf;
    logic rx_und;
    logic rx_ovf;
  } err_ev_t;
endpackage

// File: rtl/sfifo_buf.sv
module sfifo_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty,
  output logic                         ovf,
  output logic                         und
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !flush && !full;
  assign pop_ok  = pop  && !flush && !empty;
  assign ovf     = push && !flush && full;
  assign und     = pop  && !flush && empty;
  assign level   = cnt;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (pop_ok) rdata <= mem[rptr];
    else if (und)    rdata <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sfifo_cfg.sv
module sfifo_cfg
  import spi_fifo_pkg::*;
#(
  parameter int TW   = 5,
  parameter int REGW = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [REGW-1:0]           reg_wdata,
  input  logic [NTH-1:0]            thr_wr,
  input  logic                      mask_wr,
  input  logic                      dmaen_wr,
  output logic [NTH-1:0][TW-1:0]    thr_q,
  output logic [NIRQ-1:0]           mask_q,
  output logic [NDE-1:0]            dmaen_q
);
  // threshold slots: writable only while the block is stopped
  for (genvar g = 0; g < NTH; g++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst)                   thr_q[g] <= '0;
      else if (thr_wr[g] && !en) thr_q[g] <= reg_wdata[TW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      dmaen_q <= '0;
    end else begin
      if (mask_wr)  mask_q  <= reg_wdata[NIRQ-1:0];
      if (dmaen_wr) dmaen_q <= reg_wdata[NDE-1:0];
    end
  end
endmodule

// File: rtl/sfifo_irq.sv
module sfifo_irq
  import spi_fifo_pkg::*;
#(
  parameter int LW = 6,
  parameter int TW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LW-1:0]   tx_level,
  input  logic [LW-1:0]   rx_level,
  input  logic [TW-1:0]   tx_thr,
  input  logic [TW-1:0]   rx_thr,
  input  err_ev_t         ev,
  input  logic            clr_wr,
  input  logic [NCLR-1:0] clr_data,
  input  logic [NIRQ-1:0] mask,
  output logic [NIRQ-1:0] raw,
  output logic [NIRQ-1:0] masked,
  output logic            irq
);
  err_ev_t sticky_q;
  err_ev_t clr_hit;

  always_comb begin
    clr_hit        = '0;
    if (clr_wr) begin
      clr_hit.tx_ovf = clr_data[CL_ALL] | clr_data[CL_TXOVF];
      clr_hit.rx_und = clr_data[CL_ALL] | clr_data[CL_RXUND];
      clr_hit.rx_ovf = clr_data[CL_ALL] | clr_data[CL_RXOVF];
    end
  end

  // a new event in the clear cycle survives the clear
  always_ff @(posedge clk) begin
    if (rst) sticky_q <= '0;
    else     sticky_q <= ev | (sticky_q & ~clr_hit);
  end

  always_comb begin
    raw             = '0;
    raw[IR_TXEMPTY] = (tx_level <= LW'(tx_thr));
    raw[IR_TXOVF]   = sticky_q.tx_ovf;
    raw[IR_RXUND]   = sticky_q.rx_und;
    raw[IR_RXOVF]   = sticky_q.rx_ovf;
    raw[IR_RXTHR]   = (rx_level > LW'(rx_thr));
    masked          = raw & mask;
    irq             = |masked;
  end
endmodule

// File: rtl/spi_fifo_stat_irq.sv
module spi_fifo_stat_irq
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  parameter int REGW  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        tx_wr,
  input  logic [DW-1:0]               tx_wdata,
  input  logic                        rx_rd,
  output logic [DW-1:0]               rx_rdata,
  input  logic                        eng_pop,
  output logic [DW-1:0]               eng_txdata,
  input  logic                        eng_push,
  input  logic [DW-1:0]               eng_rxdata,
  input  logic                        eng_busy,
  input  logic                        eng_slv_busy,
  input  logic [REGW-1:0]             reg_wdata,
  input  logic                        txthr_wr,
  input  logic                        rxthr_wr,
  input  logic                        txdlvl_wr,
  input  logic                        rxdlvl_wr,
  input  logic                        mask_wr,
  input  logic                        clr_wr,
  input  logic                        dmaen_wr,
  output logic [$clog2(DEPTH+1)-1:0]  tx_level,
  output logic [$clog2(DEPTH+1)-1:0]  rx_level,
  output logic [5:0]                  status,
  output logic [4:0]                  irq_raw,
  output logic [4:0]                  irq_masked,
  output logic                        irq,
  output logic                        dma_tx_req,
  output logic                        dma_rx_req
);
  localparam int LW = $clog2(DEPTH+1);
  localparam int TW = $clog2(DEPTH);

  logic                   flush;
  logic                   tx_full, tx_empty, rx_full, rx_empty;
  logic                   tx_ovf, tx_und, rx_ovf, rx_und;
  logic [NTH-1:0][TW-1:0] thr;
  logic [NIRQ-1:0]        mask;
  logic [NDE-1:0]         dmaen;
  err_ev_t                ev;
  logic                   unused_bits;

  assign flush       = !en;
  assign unused_bits = tx_und ^ (^reg_wdata[REGW-1:TW]);

  sfifo_buf #(.DW(DW), .DEPTH(DEPTH)) tx_fifo_i (
    .clk(clk), .rst(rst), .flush(flush),
    .push(tx_wr), .wdata(tx_wdata), .pop(eng_pop), .rdata(eng_txdata),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .ovf(tx_ovf), .und(tx_und)
  );

  sfifo_buf #(.DW(DW), .DEPTH(DEPTH)) rx_fifo_i (
    .clk(clk), .rst(rst), .flush(flush),
    .push(eng_push), .wdata(eng_rxdata), .pop(rx_rd), .rdata(rx_rdata),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .ovf(rx_ovf), .und(rx_und)
  );

  sfifo_cfg #(.TW(TW), .REGW(REGW)) cfg_i (
    .clk(clk), .rst(rst), .en(en), .reg_wdata(reg_wdata),
    .thr_wr({rxdlvl_wr, txdlvl_wr, rxthr_wr, txthr_wr}),
    .mask_wr(mask_wr), .dmaen_wr(dmaen_wr),
    .thr_q(thr), .mask_q(mask), .dmaen_q(dmaen)
  );

  assign ev.tx_ovf = tx_ovf;
  assign ev.rx_und = rx_und;
  assign ev.rx_ovf = rx_ovf;

  sfifo_irq #(.LW(LW), .TW(TW)) irq_i (
    .clk(clk), .rst(rst),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(thr[TH_TX]), .rx_thr(thr[TH_RX]),
    .ev(ev), .clr_wr(clr_wr), .clr_data(reg_wdata[NCLR-1:0]), .mask(mask),
    .raw(irq_raw), .masked(irq_masked), .irq(irq)
  );

  always_comb begin
    status             = '0;
    status[ST_BUSY]    = eng_busy;
    status[ST_TXFULL]  = tx_full;
    status[ST_TXEMPTY] = tx_empty;
    status[ST_RXEMPTY] = rx_empty;
    status[ST_RXFULL]  = rx_full;
    status[ST_SLVBUSY] = eng_slv_busy;
  end

  assign dma_rx_req = en && dmaen[DE_RX] && (rx_level >  LW'(thr[TH_RXD]));
  assign dma_tx_req = en && dmaen[DE_TX] && (tx_level <= LW'(thr[TH_TXD]));
endmodule

// File: rtl/spi_fifo_stat_irq_chk.sv
module spi_fifo_stat_irq_chk #(
  parameter int DEPTH = 32,
  parameter int DW    = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        en,
  input logic                        tx_wr,
  input logic                        rx_rd,
  input logic                        clr_wr,
  input logic [DW-1:0]               rx_rdata,
  input logic [$clog2(DEPTH+1)-1:0]  tx_level,
  input logic [$clog2(DEPTH+1)-1:0]  rx_level,
  input logic [5:0]                  status,
  input logic [4:0]                  irq_raw,
  input logic [4:0]                  irq_masked,
  input logic                        irq,
  input logic                        dma_tx_req,
  input logic                        dma_rx_req
);
  localparam int LW = $clog2(DEPTH+1);

  a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

  a_r2_tx_step: assert property (@(posedge clk) disable iff (rst)
    $past(en) && en |-> (tx_level == $past(tx_level)) ||
                        (tx_level == $past(tx_level) + 1'b1) ||
                        (tx_level + 1'b1 == $past(tx_level)));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    en && tx_wr && (tx_level == LW'(DEPTH)) |=> irq_raw[1] && (tx_level == LW'(DEPTH)));

  a_r4_underflow: assert property (@(posedge clk) disable iff (rst)
    en && rx_rd && (rx_level == '0) |=> irq_raw[2] && (rx_rdata == '0));

  a_r5_empty_flags: assert property (@(posedge clk) disable iff (rst)
    (status[2] == (tx_level == '0)) && (status[3] == (rx_level == '0)));

  a_r8_sticky_rxovf: assert property (@(posedge clk) disable iff (rst)
    irq_raw[3] && !clr_wr |=> irq_raw[3]);

  a_r9_mask_subset: assert property (@(posedge clk) disable iff (rst)
    ((irq_masked & ~irq_raw) == '0) && (irq == (irq_masked != '0)));

  a_r10_dma_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |-> !dma_tx_req && !dma_rx_req);

  a_r11_flush: assert property (@(posedge clk) disable iff (rst)
    !en |=> (tx_level == '0) && (rx_level == '0));
endmodule

bind spi_fifo_stat_irq spi_fifo_stat_irq_chk #(.DEPTH(DEPTH), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .en(en), .tx_wr(tx_wr), .rx_rd(rx_rd), .clr_wr(clr_wr),
  .rx_rdata(rx_rdata), .tx_level(tx_level), .rx_level(rx_level), .status(status),
  .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq),
  .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
);

// File: tb/spi_fifo_stat_irq_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_stat_irq_tb_top;
  localparam int DEPTH = 32;
  localparam int DW    = 16;
  localparam int REGW  = 8;
  localparam int LW    = $clog2(DEPTH+1);

  localparam logic [2:0] OP_NOP = 3'd0;
  localparam logic [2:0] OP_TXW = 3'd1;
  localparam logic [2:0] OP_TXP = 3'd2;
  localparam logic [2:0] OP_RXP = 3'd3;
  localparam logic [2:0] OP_RXR = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] din;
    logic [7:0]  txl;
    logic [7:0]  rxl;
    logic [5:0]  st;
    logic [4:0]  raw;
    logic        chk;
    logic [15:0] dexp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{OP_TXW, 16'h00A1, 8'd1, 8'd0, 6'h08, 5'h00, 1'b0, 16'h0000},
    '{OP_TXW, 16'h00B2, 8'd2, 8'd0, 6'h08, 5'h00, 1'b0, 16'h0000},
    '{OP_TXP, 16'h0000, 8'd1, 8'd0, 6'h08, 5'h00, 1'b1, 16'h00A1},
    '{OP_TXP, 16'h0000, 8'd0, 8'd0, 6'h0C, 5'h01, 1'b1, 16'h00B2},
    '{OP_TXP, 16'h0000, 8'd0, 8'd0, 6'h0C, 5'h01, 1'b1, 16'h0000},
    '{OP_RXP, 16'h005C, 8'd0, 8'd1, 6'h04, 5'h11, 1'b0, 16'h0000},
    '{OP_RXP, 16'h003D, 8'd0, 8'd2, 6'h04, 5'h11, 1'b0, 16'h0000},
    '{OP_RXR, 16'h0000, 8'd0, 8'd1, 6'h04, 5'h11, 1'b1, 16'h005C},
    '{OP_RXR, 16'h0000, 8'd0, 8'd0, 6'h0C, 5'h01, 1'b1, 16'h003D},
    '{OP_RXR, 16'h0000, 8'd0, 8'd0, 6'h0C, 5'h05, 1'b1, 16'h0000},
    '{OP_NOP, 16'h0000, 8'd0, 8'd0, 6'h0C, 5'h05, 1'b0, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic tx_wr = 1'b0, rx_rd = 1'b0, eng_pop = 1'b0, eng_push = 1'b0;
  logic eng_busy = 1'b0, eng_slv_busy = 1'b0;
  logic [DW-1:0] tx_wdata = '0, eng_rxdata = '0;
  logic [REGW-1:0] reg_wdata = '0;
  logic txthr_wr = 1'b0, rxthr_wr = 1'b0, txdlvl_wr = 1'b0, rxdlvl_wr = 1'b0;
  logic mask_wr = 1'b0, clr_wr = 1'b0, dmaen_wr = 1'b0;
  logic [DW-1:0] rx_rdata, eng_txdata;
  logic [LW-1:0] tx_level, rx_level;
  logic [5:0] status;
  logic [4:0] irq_raw, irq_masked;
  logic irq, dma_tx_req, dma_rx_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_fifo_stat_irq #(.DEPTH(DEPTH), .DW(DW), .REGW(REGW)) dut_i (
    .clk(clk), .rst(rst), .en(en),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .eng_pop(eng_pop), .eng_txdata(eng_txdata), .eng_push(eng_push),
    .eng_rxdata(eng_rxdata), .eng_busy(eng_busy), .eng_slv_busy(eng_slv_busy),
    .reg_wdata(reg_wdata), .txthr_wr(txthr_wr), .rxthr_wr(rxthr_wr),
    .txdlvl_wr(txdlvl_wr), .rxdlvl_wr(rxdlvl_wr), .mask_wr(mask_wr),
    .clr_wr(clr_wr), .dmaen_wr(dmaen_wr),
    .tx_level(tx_level), .rx_level(rx_level), .status(status),
    .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one clock edge; strobes drop just after it, outputs are read there
  task automatic step();
    @(posedge clk);
    #1;
    tx_wr = 1'b0; rx_rd = 1'b0; eng_pop = 1'b0; eng_push = 1'b0;
    txthr_wr = 1'b0; rxthr_wr = 1'b0; txdlvl_wr = 1'b0; rxdlvl_wr = 1'b0;
    mask_wr = 1'b0; clr_wr = 1'b0; dmaen_wr = 1'b0;
  endtask

  task automatic txw(input logic [DW-1:0] d);
    tx_wr = 1'b1; tx_wdata = d; step();
  endtask
  task automatic txp();
    eng_pop = 1'b1; step();
  endtask
  task automatic rxp(input logic [DW-1:0] d);
    eng_push = 1'b1; eng_rxdata = d; step();
  endtask
  task automatic rxr();
    rx_rd = 1'b1; step();
  endtask
  task automatic clr(input logic [REGW-1:0] d);
    clr_wr = 1'b1; reg_wdata = d; step();
  endtask
  task automatic set_mask(input logic [REGW-1:0] d);
    mask_wr = 1'b1; reg_wdata = d; step();
  endtask
  task automatic set_en(input logic v);
    en = v; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    finish_run();
  end

  initial begin
    #1;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1", "tx_level", 32'(tx_level), 0);
    chk("R1", "rx_level", 32'(rx_level), 0);
    chk("R1", "status", 32'(status), 32'h0C);
    chk("R1", "irq_raw", 32'(irq_raw), 32'h01);
    chk("R1", "irq_masked", 32'(irq_masked), 0);
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "dma reqs", 32'({dma_tx_req, dma_rx_req}), 0);
    chk("R1", "data outs", 32'({rx_rdata, eng_txdata}), 0);

    set_en(1'b1);
    // R2 vector walk: ordering, levels, read data
    for (int v = 0; v < NV; v++) begin
      case (VECS[v].op)
        OP_TXW:  txw(VECS[v].din);
        OP_TXP:  txp();
        OP_RXP:  rxp(VECS[v].din);
        OP_RXR:  rxr();
        default: step();
      endcase
      chk("R2", "vec tx_level", 32'(tx_level), 32'(VECS[v].txl));
      chk("R2", "vec rx_level", 32'(rx_level), 32'(VECS[v].rxl));
      chk("R5", "vec status", 32'(status), 32'(VECS[v].st));
      chk("R4", "vec irq_raw", 32'(irq_raw), 32'(VECS[v].raw));
      if (VECS[v].chk) begin
        if (VECS[v].op == OP_TXP) chk("R2", "vec eng_txdata", 32'(eng_txdata), 32'(VECS[v].dexp));
        else                      chk("R2", "vec rx_rdata", 32'(rx_rdata), 32'(VECS[v].dexp));
      end
    end

    clr(8'h02);
    chk("R8", "clear underflow", 32'(irq_raw), 32'h01);

    // R3 transmit overflow
    for (int i = 0; i < DEPTH; i++) txw(DW'(i + 16));
    chk("R3", "tx full level", 32'(tx_level), DEPTH);
    chk("R5", "tx full status", 32'(status), 32'h0A);
    txw(16'h00EE);
    chk("R3", "level after drop", 32'(tx_level), DEPTH);
    chk("R3", "overflow bit", 32'(irq_raw), 32'h02);
    for (int i = 0; i < DEPTH; i++) begin
      txp();
      chk("R3", "tx order after drop", 32'(eng_txdata), 32'(i + 16));
    end
    chk("R6", "tx empty raw", 32'(irq_raw), 32'h03);

    // R4 receive overflow and underflow
    for (int i = 0; i < DEPTH; i++) rxp(DW'(i + 64));
    chk("R5", "rx full status", 32'(status), 32'h14);
    rxp(16'h0099);
    chk("R4", "rx level after drop", 32'(rx_level), DEPTH);
    chk("R4", "rx overflow raw", 32'(irq_raw), 32'h1B);
    for (int i = 0; i < DEPTH; i++) begin
      rxr();
      chk("R4", "rx order after drop", 32'(rx_rdata), 32'(i + 64));
    end
    rxr();
    chk("R4", "empty read data", 32'(rx_rdata), 0);
    chk("R4", "underflow raw", 32'(irq_raw), 32'h0F);

    // R8 clear bit order
    clr(8'h04);
    chk("R8", "clr bit2 -> rx ovf", 32'(irq_raw), 32'h07);
    clr(8'h08);
    chk("R8", "clr bit3 -> tx ovf", 32'(irq_raw), 32'h05);
    clr(8'h02);
    chk("R8", "clr bit1 -> rx und", 32'(irq_raw), 32'h01);
    rxr();
    clr(8'h01);
    chk("R8", "clr all", 32'(irq_raw), 32'h01);
    rx_rd = 1'b1; clr_wr = 1'b1; reg_wdata = 8'h02; step();
    chk("R8", "event beats clear", 32'(irq_raw), 32'h05);
    clr(8'h01);

    // R9 mask
    rxp(16'h0077);
    chk("R6", "rx threshold raw", 32'(irq_raw), 32'h11);
    chk("R9", "mask zero irq", 32'({irq_masked, irq}), 0);
    set_mask(8'h10);
    chk("R9", "mask rx thr", 32'(irq_masked), 32'h10);
    chk("R9", "irq on", 32'(irq), 1);
    set_mask(8'h0E);
    chk("R9", "mask sticky only", 32'({irq_masked, irq}), 0);
    set_mask(8'h01);
    chk("R9", "mask tx empty", 32'({irq_masked, irq}), 32'h03);
    set_mask(8'h00);

    // R7 threshold locked while enabled
    rxthr_wr = 1'b1; reg_wdata = 8'd3; step();
    chk("R7", "locked rx thr", 32'(irq_raw), 32'h11);

    // R11 disable flush
    set_en(1'b0);
    chk("R11", "levels after disable", 32'({tx_level, rx_level}), 0);
    chk("R11", "status after disable", 32'(status), 32'h0C);
    txw(16'h0055);
    rxp(16'h0055);
    rxr();
    chk("R11", "disabled accesses", 32'({tx_level, rx_level}), 0);
    chk("R11", "no error when disabled", 32'(irq_raw), 32'h01);

    rxthr_wr = 1'b1; reg_wdata = 8'd3; step();
    txthr_wr = 1'b1; reg_wdata = 8'd2; step();
    set_en(1'b1);
    for (int i = 0; i < 3; i++) rxp(DW'(i));
    chk("R6", "rx at thr", 32'(irq_raw), 32'h01);
    rxp(16'h0003);
    chk("R6", "rx above thr", 32'(irq_raw), 32'h11);
    for (int i = 0; i < 3; i++) txw(DW'(i));
    chk("R6", "tx above thr", 32'(irq_raw), 32'h10);
    txp();
    chk("R6", "tx at thr", 32'(irq_raw), 32'h11);
    set_en(1'b0);

    // R10 DMA requests
    rxdlvl_wr = 1'b1; reg_wdata = 8'd1; step();
    txdlvl_wr = 1'b1; reg_wdata = 8'd1; step();
    dmaen_wr = 1'b1; reg_wdata = 8'h03; step();
    chk("R10", "quiet while disabled", 32'({dma_tx_req, dma_rx_req}), 0);
    set_en(1'b1);
    chk("R10", "tx req at level 0", 32'({dma_tx_req, dma_rx_req}), 32'h2);
    txw(16'h0001);
    chk("R10", "tx req at level 1", 32'(dma_tx_req), 1);
    txw(16'h0002);
    chk("R10", "tx req off at 2", 32'(dma_tx_req), 0);
    rxp(16'h0001);
    chk("R10", "rx req off at 1", 32'(dma_rx_req), 0);
    rxp(16'h0002);
    chk("R10", "rx req at 2", 32'(dma_rx_req), 1);
    txp();
    chk("R10", "tx req back", 32'({dma_tx_req, dma_rx_req}), 32'h3);
    dmaen_wr = 1'b1; reg_wdata = 8'h01; step();
    chk("R10", "rx only enable", 32'({dma_tx_req, dma_rx_req}), 32'h1);
    dmaen_wr = 1'b1; reg_wdata = 8'h02; step();
    chk("R10", "tx only enable", 32'({dma_tx_req, dma_rx_req}), 32'h2);

    // R5 busy inputs
    eng_busy = 1'b1; #1;
    chk("R5", "busy bit", 32'(status), 32'h01);
    eng_busy = 1'b0; eng_slv_busy = 1'b1; #1;
    chk("R5", "slave busy bit", 32'(status), 32'h20);
    eng_slv_busy = 1'b0;
    step();

    finish_run();
  end
endmodule